// File: doc/BRIEF.md
# CAN Fault-Confinement State Change Interrupt Filter

This block follows the fault-confinement state of a CAN controller in both directions, receive and transmit, starting from the error counter values and a bus-off indication supplied by the protocol engine. Each direction is classified into one of four states. A programmable two-bit sensitivity code per direction decides which state transitions are significant enough to set a pending status-change flag. That flag drives the error interrupt request.

Software reads and writes a small register interface. It programs the interrupt enables and the two sensitivity codes, reads the reported states, and clears the pending flag by writing a one to it. While the flag is pending, the reported states are frozen, so software sees the state that caused the interrupt. Three further event inputs (wake-up, receive overrun and receive buffer full) are gated by their own enables onto the wake-up, error and receive interrupt request outputs.

Top module: `canStatusIrq`

## Requirements
- R1: Each direction reports a 2-bit state from its error counter: 00 OK for 0 to 95, 01 warning for 96 to 127, 10 error for 128 and above. The state can be read at address 1, with the receiver in bits [1:0] and the transmitter in bits [3:2].
- R2: The transmitter state is 11 (bus-off) when its counter is 256 or more, or when `busOffIn` is high. Whenever the transmitter is bus-off, the receiver also reports 11.
- R3: In the cycle in which the transmitter leaves bus-off, the receiver state is OK (00) whatever its counter holds. From the following cycle, the receiver state follows its counter again.
- R4: Sensitivity code 00 for a direction never sets the status-change flag. The receiver code is in control register (address 0) bits [5:4] and the transmitter code is in bits [7:6].
- R5: Sensitivity code 01 sets the flag only on transitions into or out of bus-off.
- R6: Sensitivity code 10 sets the flag only on transitions that enter or leave the error or bus-off states. Transitions between OK and warning are ignored.
- R7: Sensitivity code 11 sets the flag on every state change of that direction.
- R8: The flag is status bit 4. It becomes 1 on the clock edge that follows a qualifying transition. While it is set, the reported states hold. While it is clear, the reported states load the current states on every clock.
- R9: Writing address 1 with bit 4 at 1 clears the flag. The reported states load the current states on the clock after the clear.
- R10: If a qualifying transition coincides with a clear write, the flag stays set.
- R11: Control bit 0 enables `wakeIrq` from `wakeEvt`. Bit 2 enables `rxIrq` from `rxFullEvt`. `errIrq` is raised by `overrunEvt` when bit 1 is set, or by the pending flag when bit 3 is set.
- R12: After reset, both states are OK, and the control register, the flag and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txErrCnt | input | CNT_W | Transmit error counter value |
| rxErrCnt | input | CNT_W | Receive error counter value |
| busOffIn | input | 1 | Bus-off indication from the protocol engine |
| wakeEvt | input | 1 | Wake-up event |
| overrunEvt | input | 1 | Receive overrun event |
| rxFullEvt | input | 1 | Receive buffer full event |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (0 control, 1 status) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| wakeIrq | output | 1 | Wake-up interrupt request |
| errIrq | output | 1 | Error interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The filter is exercised with counter walks that step each direction through OK, warning, error and bus-off, under every sensitivity code. Each walk shows which transitions a code accepts and which it discards: an OK-to-warning step separates code 10 from code 11, and an error-to-warning step separates code 10 from code 01. Separate sequences change a counter while the flag is pending, clear the flag, and clear it in the same cycle as a new transition. Together these show the freeze, the one-cycle reload delay and the priority of a set over a clear. A bus-off release with a high receive counter isolates the forced receiver OK cycle.

// File: rtl/canStatPkg.sv
package canStatPkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_WARN   = 2'b01,
    ST_ERR    = 2'b10,
    ST_BUSOFF = 2'b11
  } faultState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStatus;
  } dpStrobe_t;

  localparam int NUM_DIR = 2;
  localparam int DIR_RX  = 0;
  localparam int DIR_TX  = 1;
endpackage

// File: rtl/canStatDatapath.sv
module canStatDatapath
  import canStatPkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int WARN_LIM   = 96,
  parameter int ERR_LIM    = 128,
  parameter int BUSOFF_LIM = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  input  logic             busOffIn,
  input  dpStrobe_t        strobe,
  output faultState_e      rxCur,
  output faultState_e      txCur,
  output faultState_e      rxPrev,
  output faultState_e      txPrev,
  output faultState_e      rxStat,
  output faultState_e      txStat
);
  localparam logic [CNT_W-1:0] warnT = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] errT  = CNT_W'(ERR_LIM);
  localparam logic [CNT_W-1:0] boT   = CNT_W'(BUSOFF_LIM);

  faultState_e curSt  [NUM_DIR];
  faultState_e prevQ  [NUM_DIR];
  faultState_e statQ  [NUM_DIR];

  function automatic faultState_e levelOf(input logic [CNT_W-1:0] cnt);
    if (cnt >= errT)       return ST_ERR;
    else if (cnt >= warnT) return ST_WARN;
    else                   return ST_OK;
  endfunction

  always_comb begin
    if (busOffIn || (txCnt >= boT)) curSt[DIR_TX] = ST_BUSOFF;
    else                            curSt[DIR_TX] = levelOf(txCnt);
    // receiver mirrors transmitter bus-off and is forced OK on its exit
    if (curSt[DIR_TX] == ST_BUSOFF)     curSt[DIR_RX] = ST_BUSOFF;
    else if (prevQ[DIR_TX] == ST_BUSOFF) curSt[DIR_RX] = ST_OK;
    else                                 curSt[DIR_RX] = levelOf(rxCnt);
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevQ[d] <= ST_OK;
        statQ[d] <= ST_OK;
      end else begin
        prevQ[d] <= curSt[d];
        if (strobe.loadStatus) statQ[d] <= curSt[d];
      end
    end
  end

  assign rxCur  = curSt[DIR_RX];
  assign txCur  = curSt[DIR_TX];
  assign rxPrev = prevQ[DIR_RX];
  assign txPrev = prevQ[DIR_TX];
  assign rxStat = statQ[DIR_RX];
  assign txStat = statQ[DIR_TX];
endmodule

// File: rtl/canStatCtrl.sv
module canStatCtrl
  import canStatPkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  faultState_e       rxCur,
  input  faultState_e       txCur,
  input  faultState_e       rxPrev,
  input  faultState_e       txPrev,
  input  faultState_e       rxStat,
  input  faultState_e       txStat,
  input  logic              wakeEvt,
  input  logic              overrunEvt,
  input  logic              rxFullEvt,
  output dpStrobe_t         strobe,
  output logic              chgFlag,
  output logic [1:0]        rxSens,
  output logic [1:0]        txSens,
  output logic              wakeIrq,
  output logic              errIrq,
  output logic              rxIrq
);
  localparam logic [ADDR_W-1:0] ctrlAddr = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] statAddr = ADDR_W'(STAT_ADDR);
  localparam int BIT_WAKE = 0;
  localparam int BIT_OVR  = 1;
  localparam int BIT_RXF  = 2;
  localparam int BIT_CHG  = 3;
  localparam int BIT_FLAG = 4;

  logic [7:0] ctrlQ;
  logic       chgFlagQ;
  logic       chgEvt;
  logic       clearReq;

  function automatic logic qualify(input logic [1:0] code,
                                   input faultState_e prev,
                                   input faultState_e cur);
    logic moved;
    moved = (prev != cur);
    case (code)
      2'b01:   return (prev == ST_BUSOFF) != (cur == ST_BUSOFF);
      2'b10:   return moved && (prev[1] || cur[1]);
      2'b11:   return moved;
      default: return 1'b0;
    endcase
  endfunction

  assign rxSens   = ctrlQ[5:4];
  assign txSens   = ctrlQ[7:6];
  assign chgEvt   = qualify(rxSens, rxPrev, rxCur) | qualify(txSens, txPrev, txCur);
  assign clearReq = regWrEn && (regAddr == statAddr) && regWrData[BIT_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ    <= '0;
      chgFlagQ <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == ctrlAddr)) ctrlQ <= regWrData;
      if (chgEvt)        chgFlagQ <= 1'b1;
      else if (clearReq) chgFlagQ <= 1'b0;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadStatus = !chgFlagQ;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ctrlAddr)      regRdData = ctrlQ;
    else if (regAddr == statAddr) regRdData = {3'b000, chgFlagQ, txStat, rxStat};
  end

  assign chgFlag = chgFlagQ;
  assign wakeIrq = wakeEvt & ctrlQ[BIT_WAKE];
  assign rxIrq   = rxFullEvt & ctrlQ[BIT_RXF];
  assign errIrq  = (chgFlagQ & ctrlQ[BIT_CHG]) | (overrunEvt & ctrlQ[BIT_OVR]);
endmodule

// File: rtl/canStatusIrq.sv
module canStatusIrq
  import canStatPkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int WARN_LIM   = 96,
  parameter int ERR_LIM    = 128,
  parameter int BUSOFF_LIM = 256,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              busOffIn,
  input  logic              wakeEvt,
  input  logic              overrunEvt,
  input  logic              rxFullEvt,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              wakeIrq,
  output logic              errIrq,
  output logic              rxIrq
);
  localparam int STAT_ADDR = 1;

  dpStrobe_t   strobe;
  faultState_e rxCur, txCur, rxPrev, txPrev, rxStat, txStat;
  logic        chgFlag;
  logic [1:0]  rxSens, txSens;
  logic        clearWr;

  canStatDatapath #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .ERR_LIM(ERR_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .txCnt(txErrCnt), .rxCnt(rxErrCnt),
    .busOffIn(busOffIn), .strobe(strobe),
    .rxCur(rxCur), .txCur(txCur), .rxPrev(rxPrev), .txPrev(txPrev),
    .rxStat(rxStat), .txStat(txStat)
  );

  canStatCtrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(0), .STAT_ADDR(STAT_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxCur(rxCur), .txCur(txCur), .rxPrev(rxPrev), .txPrev(txPrev),
    .rxStat(rxStat), .txStat(txStat),
    .wakeEvt(wakeEvt), .overrunEvt(overrunEvt), .rxFullEvt(rxFullEvt),
    .strobe(strobe), .chgFlag(chgFlag), .rxSens(rxSens), .txSens(txSens),
    .wakeIrq(wakeIrq), .errIrq(errIrq), .rxIrq(rxIrq)
  );

  assign clearWr = regWrEn && (regAddr == ADDR_W'(STAT_ADDR)) && regWrData[4];

  assert_rx_busoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (txCur == ST_BUSOFF) |-> (rxCur == ST_BUSOFF));

  assert_busoff_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txPrev == ST_BUSOFF && txCur != ST_BUSOFF) |-> (rxCur == ST_OK));

  assert_quiet_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxSens == 2'b00 && txSens == 2'b00 && !chgFlag) |=> !chgFlag);

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chgFlag |=> $stable({rxStat, txStat}));

  assert_tracking_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chgFlag |=> ({rxStat, txStat} == $past({rxCur, txCur})));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chgFlag && clearWr && rxCur == rxPrev && txCur == txPrev) |=> !chgFlag);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chgFlag && !clearWr) |=> chgFlag);
endmodule

// File: tb/canStatusIrq_tb.sv
module canStatusIrq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] txErrCnt = '0, rxErrCnt = '0;
  logic       busOffIn = 1'b0, wakeEvt = 1'b0, overrunEvt = 1'b0, rxFullEvt = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       wakeIrq, errIrq, rxIrq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  canStatusIrq u_dut (
    .clk(clk), .rst_n(rst_n), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .busOffIn(busOffIn), .wakeEvt(wakeEvt), .overrunEvt(overrunEvt),
    .rxFullEvt(rxFullEvt), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .wakeIrq(wakeIrq), .errIrq(errIrq), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setCnt(input int tx, input int rx, input logic bo);
    @(negedge clk);
    txErrCnt = 9'(tx); rxErrCnt = 9'(rx); busOffIn = bo;
  endtask

  // apply counters, let one edge pass, return the flag bit
  task automatic flagAfter(input int tx, input int rx, input logic bo, output int f);
    logic [7:0] v;
    setCnt(tx, rx, bo);
    step();
    rd(2'd1, v);
    f = int'(v[4]);
  endtask

  task automatic settle();
    wr(2'd0, 8'h00);
    setCnt(0, 0, 1'b0);
    step(); step();
    wr(2'd1, 8'h10);
    step();
    wakeEvt = 0; overrunEvt = 0; rxFullEvt = 0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(2'd0, v); chk("R12 ctrl", int'(v), 0);
    rd(2'd1, v); chk("R12 status", int'(v), 0);
    chk("R12 irqs", int'({wakeIrq, errIrq, rxIrq}), 0);
  endtask

  task automatic testDecode();
    logic [7:0] v;
    settle();
    setCnt(127, 95, 1'b0); step(); rd(2'd1, v);
    chk("R1 tx 127", int'(v[3:2]), 1); chk("R1 rx 95", int'(v[1:0]), 0);
    setCnt(128, 96, 1'b0); step(); rd(2'd1, v);
    chk("R1 tx 128", int'(v[3:2]), 2); chk("R1 rx 96", int'(v[1:0]), 1);
    setCnt(95, 300, 1'b0); step(); rd(2'd1, v);
    chk("R1 tx 95", int'(v[3:2]), 0); chk("R1 rx 300", int'(v[1:0]), 2);
  endtask

  task automatic testBusOff();
    logic [7:0] v;
    settle();
    setCnt(255, 0, 1'b0); step(); rd(2'd1, v);
    chk("R2 tx 255", int'(v[3:0]), 8);
    setCnt(256, 0, 1'b0); step(); rd(2'd1, v);
    chk("R2 tx 256", int'(v[3:0]), 15);
    setCnt(0, 0, 1'b1); step(); rd(2'd1, v);
    chk("R2 busOffIn", int'(v[3:0]), 15);
    setCnt(0, 200, 1'b0); step(); rd(2'd1, v);
    chk("R3 exit cycle rx", int'(v[1:0]), 0); chk("R3 exit tx", int'(v[3:2]), 0);
    step(); rd(2'd1, v);
    chk("R3 rx follows after", int'(v[1:0]), 2);
  endtask

  task automatic testCode00();
    int f;
    settle();
    flagAfter(150, 0, 1'b0, f); chk("R4 tx err", f, 0);
    flagAfter(150, 0, 1'b1, f); chk("R4 busoff", f, 0);
    flagAfter(0, 0, 1'b0, f);   chk("R4 exit", f, 0);
  endtask

  task automatic testCode01();
    int f;
    settle();
    wr(2'd0, 8'h10);
    flagAfter(0, 100, 1'b0, f); chk("R5 rx warn", f, 0);
    flagAfter(0, 200, 1'b0, f); chk("R5 rx err", f, 0);
    flagAfter(0, 100, 1'b0, f); chk("R5 rx err->warn", f, 0);
    flagAfter(0, 100, 1'b1, f); chk("R5 rx enter busoff", f, 1);
    wr(2'd1, 8'h10);
    flagAfter(0, 0, 1'b0, f);   chk("R5 rx leave busoff", f, 1);
  endtask

  task automatic testCode10();
    int f;
    settle();
    wr(2'd0, 8'h80);
    flagAfter(100, 0, 1'b0, f); chk("R6 ok->warn", f, 0);
    flagAfter(150, 0, 1'b0, f); chk("R6 warn->err", f, 1);
    wr(2'd1, 8'h10);
    flagAfter(100, 0, 1'b0, f); chk("R6 err->warn", f, 1);
    wr(2'd1, 8'h10);
    flagAfter(50, 0, 1'b0, f);  chk("R6 warn->ok", f, 0);
  endtask

  task automatic testCode11();
    int f;
    settle();
    wr(2'd0, 8'h30);
    flagAfter(0, 100, 1'b0, f); chk("R7 ok->warn", f, 1);
    wr(2'd1, 8'h10);
    flagAfter(0, 50, 1'b0, f);  chk("R7 warn->ok", f, 1);
  endtask

  task automatic testFreeze();
    logic [7:0] v;
    settle();
    wr(2'd0, 8'h30);
    setCnt(0, 100, 1'b0); step(); rd(2'd1, v);
    chk("R8 flag set", int'(v[4]), 1); chk("R8 loaded", int'(v[1:0]), 1);
    setCnt(0, 200, 1'b0); step(); rd(2'd1, v);
    chk("R8 frozen", int'(v[1:0]), 1);
    wr(2'd1, 8'h10); rd(2'd1, v);
    chk("R9 cleared", int'(v[4]), 0); chk("R9 still old", int'(v[1:0]), 1);
    step(); rd(2'd1, v);
    chk("R9 reloaded", int'(v[1:0]), 2);
  endtask

  task automatic testSetWins();
    logic [7:0] v;
    settle();
    wr(2'd0, 8'h30);
    setCnt(0, 100, 1'b0); step();
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd1; regWrData = 8'h10; rxErrCnt = 9'd200;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(2'd1, v);
    chk("R10 flag kept", int'(v[4]), 1);
  endtask

  task automatic testIrqs();
    settle();
    wr(2'd0, 8'h07);
    wakeEvt = 1; overrunEvt = 1; rxFullEvt = 1; #1;
    chk("R11 wake on", int'(wakeIrq), 1);
    chk("R11 ovr on", int'(errIrq), 1);
    chk("R11 rxfull on", int'(rxIrq), 1);
    wr(2'd0, 8'h00); #1;
    chk("R11 all off", int'({wakeIrq, errIrq, rxIrq}), 0);
    wakeEvt = 0; overrunEvt = 0; rxFullEvt = 0;
    wr(2'd0, 8'h38);
    setCnt(0, 100, 1'b0); step(); #1;
    chk("R11 chg irq", int'(errIrq), 1);
    wr(2'd0, 8'h30); #1;
    chk("R11 chg masked", int'(errIrq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    testReset();
    testDecode();
    testBusOff();
    testCode00();
    testCode01();
    testCode10();
    testCode11();
    testFreeze();
    testSetWins();
    testIrqs();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule